// File: doc/BRIEF.md
# Transmit Jabber Guard with Heartbeat Pulse

This block sits beside a 10 Mb/s twisted-pair transmitter and watches only its transmit enable line. At the end of every ordinary frame it drives a short heartbeat pulse on the collision output. This lets the MAC confirm that the collision reporting path works.

It also guards the wire against a runaway transmitter. If enable stays asserted for longer than a trip interval, the block removes the transmitter gate and holds the collision output high. The lockout ends only after enable has stayed low for an unbroken, much longer quiet interval.

A mode input marks 10 Mb/s operation. When that input is low, the whole function is disabled and its state is cleared. All intervals are parameters counted in clock cycles. The block does not detect real collisions on the medium.

Top module: `jabber_sqe_guard`

## Requirements
- R1: After reset, `col` is 0 and `tx_gate` is 1.
- R2: In 10 Mb/s mode outside lockout, a clock cycle that samples `tx_en` low after a cycle that sampled it high starts a heartbeat. `col` is then 1 for exactly `SQE_CYC` cycles, beginning with the cycle after that low sample.
- R3: A frame whose `tx_en` stays high for at most `JAB_CYC` consecutive sampled cycles leaves `col` at 0 and `tx_gate` at 1 while it lasts.
- R4: When `tx_en` is sampled high on `JAB_CYC`+1 consecutive cycles, lockout begins. From the next cycle, `tx_gate` is 0 and `col` is 1.
- R5: During lockout, `col` stays at 1 and `tx_gate` stays at 0. Both are released in the cycle after `tx_en` has been sampled low on `QUIET_CYC`+1 consecutive cycles.
- R6: Any cycle that samples `tx_en` high during lockout restarts the quiet count from zero.
- R7: No heartbeat is produced when a transmission that caused lockout ends, nor when lockout is released.
- R8: While `mode_10m` is 0, `col` is 0 and `tx_gate` is 1 from the next cycle on. Any lockout, heartbeat or partial count is discarded, and a frame ending in this mode produces no heartbeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC |
| mode_10m | input | 1 | 1 when the link runs at 10 Mb/s |
| col | output | 1 | Collision indication: heartbeat or lockout |
| tx_gate | output | 1 | 1 while the transmitter may drive the line |

## Verification
The embedded properties check the following on every cycle:
- Whenever the gate is shut, the collision output is high.
- Lockout can start only from a cycle that sampled enable high.
- Release happens only from a low sample or when the mode is switched off.
- A heartbeat always starts at its full length.
- Leaving 10 Mb/s mode clears both outputs.

The exact cycle counts can only be shown by the bench's scenarios. These include:
- the pulse width;
- a frame one cycle short of the trip interval against one that trips;
- the quiet interval, and its restart after a stray high sample;
- the missing heartbeat after a frame that tripped lockout.

// File: rtl/jsg_pkg.sv
package jsg_pkg;
    // Registered control state of the guard
    typedef struct packed {
        logic lock;   // jabber lockout active
        logic prev;   // tx_en sampled last cycle (qualified by mode)
    } jsg_state_t;
endpackage

// File: rtl/jsg_run_timer.sv
// Counts consecutive qualifying cycles; flags the cycle that exceeds LIMIT.
module jsg_run_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = inc && !clr && (cnt_q == LIM);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/jsg_sqe_pulse.sv
// Fixed-length heartbeat pulse generator, retriggerable.
module jsg_sqe_pulse #(
    parameter int unsigned SQE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy
);
    localparam int unsigned W = $clog2(SQE_CYC + 1);
    localparam logic [W-1:0] LEN = W'(SQE_CYC);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = LEN;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R2
    sqe_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cnt_q == LEN);

    // R2
    sqe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr) |=> busy);
endmodule

// File: rtl/jabber_sqe_guard.sv
module jabber_sqe_guard
    import jsg_pkg::*;
#(
    parameter int unsigned JAB_CYC   = 200_000,
    parameter int unsigned QUIET_CYC = 2_500_000,
    parameter int unsigned SQE_CYC   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic mode_10m,
    output logic col,
    output logic tx_gate
);
    jsg_state_t st_d, st_q;
    logic run_hit, quiet_hit, sqe_busy, sqe_start;

    // Consecutive high samples while not locked
    jsg_run_timer #(.LIMIT(JAB_CYC)) i_run (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!tx_en || st_q.lock || !mode_10m),
        .inc  (tx_en),
        .hit  (run_hit)
    );

    // Consecutive low samples while locked
    jsg_run_timer #(.LIMIT(QUIET_CYC)) i_quiet (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tx_en || !st_q.lock || !mode_10m),
        .inc  (!tx_en),
        .hit  (quiet_hit)
    );

    assign sqe_start = mode_10m && st_q.prev && !tx_en && !st_q.lock;

    jsg_sqe_pulse #(.SQE_CYC(SQE_CYC)) i_sqe (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!mode_10m),
        .start(sqe_start),
        .busy (sqe_busy)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = tx_en && mode_10m;
        if (!mode_10m) begin
            st_d.lock = 1'b0;
        end else if (!st_q.lock && run_hit) begin
            st_d.lock = 1'b1;
        end else if (st_q.lock && quiet_hit) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col     = st_q.lock || sqe_busy;
    assign tx_gate = !st_q.lock;

    // R5
    lock_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_gate |-> col);

    // R4
    trip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_gate) |-> $past(tx_en) && $past(mode_10m));

    // R5
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_gate) |-> !$past(tx_en) || !$past(mode_10m));

    // R8
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10m |=> !col && tx_gate);
endmodule

// File: tb/test_jabber_sqe_guard.sv
module test_jabber_sqe_guard;
    localparam int unsigned JAB   = 20;
    localparam int unsigned QUIET = 40;
    localparam int unsigned SQE   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic mode_10m = 1'b1;
    logic col, tx_gate;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  c;
        logic  g;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    jabber_sqe_guard #(.JAB_CYC(JAB), .QUIET_CYC(QUIET), .SQE_CYC(SQE)) i_jabber_sqe_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .mode_10m(mode_10m),
        .col     (col),
        .tx_gate (tx_gate)
    );

    task automatic compare(input logic ec, input logic eg, input string tag);
        checks++;
        if (col !== ec || tx_gate !== eg) begin
            fails++;
            $display("FAIL %s: col/tx_gate actual=%b/%b expected=%b/%b at %0t",
                     tag, col, tx_gate, ec, eg, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the outputs expected after the next edge
    task automatic step(input logic tx, input logic m, input logic ec, input logic eg,
                        input string tag);
        exp_t e;
        @(negedge clk);
        tx_en    = tx;
        mode_10m = m;
        e.c = ec; e.g = eg; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.c, e.g, e.tag);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        finish_run();
    end

    task automatic trip_frame(input string tag);
        for (int i = 0; i < JAB; i++) step(1'b1, 1'b1, 1'b0, 1'b1, tag);
        step(1'b1, 1'b1, 1'b1, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(1'b0, 1'b1, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(1'b0, 1'b1, "R1 after reset");

        // Ordinary frame and heartbeat
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R3 short frame");
        for (int i = 0; i < SQE; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R2 heartbeat");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R2 heartbeat end");

        // Frame exactly at the trip limit
        for (int i = 0; i < JAB; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R3 boundary frame");
        for (int i = 0; i < SQE; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R2 boundary heartbeat");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R2 boundary idle");

        // Trip, hold, quiet release
        trip_frame("R4 trip");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R5 held high");
        for (int i = 0; i < QUIET; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R5 quiet wait");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R7 released, no heartbeat");

        // Stray high sample restarts the quiet count
        trip_frame("R4 second trip");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R5 partial quiet");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6 stray high");
        for (int i = 0; i < QUIET; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R6 restarted quiet");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6 release");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R7 no heartbeat");

        // Mode off suppresses everything
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R8 long frame off");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R8 no heartbeat off");
        trip_frame("R4 third trip");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8 lockout cleared");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R8 no heartbeat on return");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R8 idle");

        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule